// File: doc/BRIEF.md
# Zero-Byte Compressed Operand Store

An addressable array of operand words in which every byte carries a stored zero flag. On a write, each incoming byte is tested for being all zeros in the same cycle. A zero byte only sets its flag, and the write enable of that byte's data storage stays low. A non-zero byte clears its flag and is written into its lane. On a read, a set flag keeps that byte's data storage from being read, and the output byte is forced to zero. The word read back therefore always equals the word that was written.

Operands may be full-width (64 bits, eight bytes) or narrow (32 bits). For a narrow write, the upper half of the word is treated as zero and flagged, whatever the upper input bits hold. One write port and a parameterised number of read ports share the array. Every access reports how many data byte lanes it actually enabled, so that the skipping of zero bytes is visible outside the block. A read of an address that is written in the same cycle returns the contents from before the write.

Top module: `zb_operand_store`

## Requirements
- R1: Reset sets every zero flag, so each address then reads back as 0 with a lane count of 0, and `rd_valid` is 0 until the first enabled read.
- R2: `wr_lanes` equals the number of non-zero bytes in `wr_data` in the same cycle that `wr_en` is high, and is 0 whenever `wr_en` is low.
- R3: A read enabled on a port returns, on that port one clock edge later, the exact 64-bit word last written to the address, including any zero bytes, with `rd_valid` high.
- R4: The `rd_lanes` value of a read equals the number of non-zero bytes in the word returned, and it is reported in the same cycle as the data.
- R5: With `wr_narrow` high, bytes 4 to 7 (bits 63:32) are stored as zero whatever `wr_data[63:32]` holds, and only bytes 0 to 3 can add to `wr_lanes`.
- R6: When the same address is read and written in one cycle, the read returns the contents from before that write. The next read returns the new word.
- R7: A port whose `rd_en` bit was low shows `rd_valid`, `rd_data` and `rd_lanes` as 0 one edge later.
- R8: Read ports work independently. Each one returns the word at its own address in the same cycle, and two ports may read the same address.
- R9: A cycle with `wr_en` low leaves the stored contents unchanged, whatever `wr_addr`, `wr_data` and `wr_narrow` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_narrow | input | 1 | 1: 32-bit operand, upper four bytes stored as zero |
| wr_addr | input | AW (3) | Write address |
| wr_data | input | 64 | Write operand |
| wr_lanes | output | CW (4) | Data byte lanes enabled by the current write |
| rd_en | input | NRD (2) | Read strobe, one bit per port |
| rd_addr | input | NRD*AW (6) | Read addresses, port p at bits [p*AW +: AW] |
| rd_data | output | NRD*64 (128) | Read words, port p at bits [p*64 +: 64] |
| rd_lanes | output | NRD*CW (8) | Data byte lanes enabled by each port's read |
| rd_valid | output | NRD (2) | Read result present, one bit per port |

## Verification
`wr_lanes` is combinational and belongs to the same cycle as the write. The bench drives the write on a falling edge and checks the count one time step later, before the next rising edge. Read data, read lane counts and `rd_valid` are registered, so they appear after the first rising edge that follows the request. The bench drives each read on a falling edge and compares the results on the next falling edge. The read-before-write case uses this timing: the write and the read go out on the same falling edge, so the word checked at the next falling edge must be the older one.

// File: rtl/zb_pkg.sv
package zb_pkg;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] lane_t;

    // width of a counter able to hold 0..n
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/zb_zero_detect.sv
module zb_zero_detect #(
    parameter int BYTES        = 8,
    parameter int NARROW_BYTES = 4,
    parameter int CW           = 4
) (
    input  logic                       en_i,
    input  logic                       narrow_i,
    input  logic [BYTES*zb_pkg::BYTE_W-1:0] word_i,
    output logic [BYTES-1:0]           zflag_o,
    output logic [CW-1:0]              lanes_o
);
    localparam int BW = zb_pkg::BYTE_W;

    genvar b;
    generate
        for (b = 0; b < BYTES; b++) begin : g_det
            if (b >= NARROW_BYTES) begin : g_upper
                assign zflag_o[b] = narrow_i | ~(|word_i[b*BW +: BW]);
            end else begin : g_lower
                assign zflag_o[b] = ~(|word_i[b*BW +: BW]);
            end
        end
    endgenerate

    always_comb begin
        lanes_o = '0;
        if (en_i) begin
            for (int i = 0; i < BYTES; i++) begin
                lanes_o = lanes_o + CW'(!zflag_o[i]);
            end
        end
    end
endmodule

// File: rtl/zb_byte_lane.sv
module zb_byte_lane #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int NRD   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic                 zero_i,
    input  logic [AW-1:0]        addr_i,
    input  zb_pkg::lane_t        byte_i,
    input  logic [NRD*AW-1:0]    rd_addr_i,
    output logic [NRD-1:0]       rd_zero_o,
    output logic [NRD*zb_pkg::BYTE_W-1:0] rd_byte_o
);
    localparam int BW = zb_pkg::BYTE_W;

    logic [DEPTH-1:0] zmap;
    zb_pkg::lane_t    mem [DEPTH];

    // zero flag: written on every write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zmap <= '1;
        end else if (we_i) begin
            zmap[addr_i] <= zero_i;
        end
    end

    // data lane: write enable gated by the zero flag
    always_ff @(posedge clk) begin
        if (we_i && !zero_i) begin
            mem[addr_i] <= byte_i;
        end
    end

    genvar p;
    generate
        for (p = 0; p < NRD; p++) begin : g_rd
            logic [AW-1:0] ra;
            assign ra           = rd_addr_i[p*AW +: AW];
            assign rd_zero_o[p] = zmap[ra];
            // read enable gated by the zero flag
            assign rd_byte_o[p*BW +: BW] = zmap[ra] ? '0 : mem[ra];
        end
    endgenerate
endmodule

// File: rtl/zb_read_port.sv
module zb_read_port #(
    parameter int BYTES = 8,
    parameter int CW    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en_i,
    input  logic [BYTES-1:0]              zero_i,
    input  logic [BYTES*zb_pkg::BYTE_W-1:0] bytes_i,
    output logic [BYTES*zb_pkg::BYTE_W-1:0] data_o,
    output logic [CW-1:0]                 lanes_o,
    output logic                          valid_o
);
    logic [CW-1:0] lane_cnt;

    always_comb begin
        lane_cnt = '0;
        for (int i = 0; i < BYTES; i++) begin
            lane_cnt = lane_cnt + CW'(!zero_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            lanes_o <= '0;
            valid_o <= 1'b0;
        end else if (en_i) begin
            data_o  <= bytes_i;
            lanes_o <= lane_cnt;
            valid_o <= 1'b1;
        end else begin
            data_o  <= '0;
            lanes_o <= '0;
            valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/zb_operand_store.sv
module zb_operand_store #(
    parameter int DEPTH = 8,
    parameter int BYTES = 8,
    parameter int NRD   = 2,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = zb_pkg::cnt_w(BYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_narrow,
    input  logic [AW-1:0]             wr_addr,
    input  logic [BYTES*8-1:0]        wr_data,
    output logic [CW-1:0]             wr_lanes,
    input  logic [NRD-1:0]            rd_en,
    input  logic [NRD*AW-1:0]         rd_addr,
    output logic [NRD*BYTES*8-1:0]    rd_data,
    output logic [NRD*CW-1:0]         rd_lanes,
    output logic [NRD-1:0]            rd_valid
);
    localparam int BW           = zb_pkg::BYTE_W;
    localparam int WW           = BYTES * BW;
    localparam int NARROW_BYTES = BYTES / 2;

    logic [BYTES-1:0]                 wr_zero;
    logic [BYTES-1:0][NRD-1:0]        lane_rz;
    logic [BYTES-1:0][NRD*BW-1:0]     lane_rb;
    logic [NRD-1:0][BYTES-1:0]        port_rz;
    logic [NRD-1:0][WW-1:0]           port_rb;

    zb_zero_detect #(
        .BYTES        (BYTES),
        .NARROW_BYTES (NARROW_BYTES),
        .CW           (CW)
    ) u_det (
        .en_i     (wr_en),
        .narrow_i (wr_narrow),
        .word_i   (wr_data),
        .zflag_o  (wr_zero),
        .lanes_o  (wr_lanes)
    );

    genvar b, p;
    generate
        for (b = 0; b < BYTES; b++) begin : g_lane
            zb_byte_lane #(
                .DEPTH (DEPTH),
                .AW    (AW),
                .NRD   (NRD)
            ) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .we_i      (wr_en),
                .zero_i    (wr_zero[b]),
                .addr_i    (wr_addr),
                .byte_i    (wr_data[b*BW +: BW]),
                .rd_addr_i (rd_addr),
                .rd_zero_o (lane_rz[b]),
                .rd_byte_o (lane_rb[b])
            );
            for (p = 0; p < NRD; p++) begin : g_xbar
                assign port_rz[p][b]           = lane_rz[b][p];
                assign port_rb[p][b*BW +: BW]  = lane_rb[b][p*BW +: BW];
            end
        end

        for (p = 0; p < NRD; p++) begin : g_port
            zb_read_port #(
                .BYTES (BYTES),
                .CW    (CW)
            ) u_rd (
                .clk     (clk),
                .rst_n   (rst_n),
                .en_i    (rd_en[p]),
                .zero_i  (port_rz[p]),
                .bytes_i (port_rb[p]),
                .data_o  (rd_data[p*WW +: WW]),
                .lanes_o (rd_lanes[p*CW +: CW]),
                .valid_o (rd_valid[p])
            );
        end
    endgenerate
endmodule

// File: rtl/zb_operand_store_chk.sv
module zb_operand_store_chk #(
    parameter int DEPTH = 8,
    parameter int BYTES = 8,
    parameter int NRD   = 2,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic                   wr_narrow,
    input logic [CW-1:0]          wr_lanes,
    input logic [NRD-1:0]         rd_en,
    input logic [NRD*BYTES*8-1:0] rd_data,
    input logic [NRD*CW-1:0]      rd_lanes,
    input logic [NRD-1:0]         rd_valid
);
    localparam int WW = BYTES * 8;

    logic [NRD-1:0][CW-1:0] nz_cnt;

    always_comb begin
        for (int q = 0; q < NRD; q++) begin
            nz_cnt[q] = '0;
            for (int i = 0; i < BYTES; i++) begin
                nz_cnt[q] = nz_cnt[q] + CW'(rd_data[q*WW + i*8 +: 8] != 8'h00);
            end
        end
    end

    a_r2_idle_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> wr_lanes == '0);

    a_r5_narrow_lane_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_narrow) |-> wr_lanes <= CW'(BYTES / 2));

    genvar p;
    generate
        for (p = 0; p < NRD; p++) begin : g_chk
            a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
                rd_en[p] |=> rd_valid[p]);

            a_r7_idle_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_en[p] |=> (!rd_valid[p] && rd_data[p*WW +: WW] == '0
                               && rd_lanes[p*CW +: CW] == '0));

            a_r4_lanes_match_data: assert property (@(posedge clk) disable iff (!rst_n)
                rd_valid[p] |-> rd_lanes[p*CW +: CW] == nz_cnt[p]);
        end
    endgenerate
endmodule

bind zb_operand_store zb_operand_store_chk #(
    .DEPTH (DEPTH),
    .BYTES (BYTES),
    .NRD   (NRD),
    .AW    (AW),
    .CW    (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_narrow (wr_narrow),
    .wr_lanes  (wr_lanes),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_lanes  (rd_lanes),
    .rd_valid  (rd_valid)
);

// File: tb/zb_operand_store_tb.sv
module zb_operand_store_tb;
    localparam int DEPTH = 8;
    localparam int BYTES = 8;
    localparam int NRD   = 2;
    localparam int AW    = 3;
    localparam int CW    = 4;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   wr_en;
    logic                   wr_narrow;
    logic [AW-1:0]          wr_addr;
    logic [63:0]            wr_data;
    logic [CW-1:0]          wr_lanes;
    logic [NRD-1:0]         rd_en;
    logic [NRD*AW-1:0]      rd_addr;
    logic [NRD*64-1:0]      rd_data;
    logic [NRD*CW-1:0]      rd_lanes;
    logic [NRD-1:0]         rd_valid;

    int checks = 0;
    int errors = 0;
    logic [63:0] model [DEPTH];

    always #5 clk = ~clk;

    zb_operand_store #(
        .DEPTH (DEPTH), .BYTES (BYTES), .NRD (NRD), .AW (AW), .CW (CW)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_narrow (wr_narrow),
        .wr_addr (wr_addr), .wr_data (wr_data), .wr_lanes (wr_lanes),
        .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
        .rd_lanes (rd_lanes), .rd_valid (rd_valid)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input int mask, input int seed);
        logic [63:0] w;
        for (int b = 0; b < 8; b++) begin
            w[b*8 +: 8] = mask[b] ? (8'((seed * 13 + b * 29 + 7)) | 8'h01) : 8'h00;
        end
        return w;
    endfunction

    function automatic int nzb(input logic [63:0] w);
        int n = 0;
        for (int b = 0; b < 8; b++) if (w[b*8 +: 8] != 8'h00) n++;
        return n;
    endfunction

    // check port p against an expected word (R3/R4 or the tag given)
    task automatic check_port(input int p, input logic [63:0] exp, input string req);
        check(rd_valid[p] == 1'b1, {req, " valid"}, 64'(rd_valid[p]), 64'd1);
        check(rd_data[p*64 +: 64] == exp, {req, " data"}, rd_data[p*64 +: 64], exp);
        check(int'(rd_lanes[p*CW +: CW]) == nzb(exp), {req, " R4 lanes"},
              64'(rd_lanes[p*CW +: CW]), 64'(nzb(exp)));
    endtask

    task automatic do_write(input int a, input logic [63:0] d, input bit nar,
                            input int exp_lanes, input string req);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_narrow = nar;
        #1;
        check(int'(wr_lanes) == exp_lanes, req, 64'(wr_lanes), 64'(exp_lanes));
        model[a] = nar ? {32'h0, d[31:0]} : d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int a0, input int a1);
        rd_en = 2'b11; rd_addr = {AW'(a1), AW'(a0)};
        @(negedge clk);
        rd_en = 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_narrow = 1'b0; wr_addr = '0; wr_data = '0;
        rd_en = '0; rd_addr = '0;
        for (int a = 0; a < DEPTH; a++) model[a] = 64'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(rd_valid == '0, "R1 valid after reset", 64'(rd_valid), 64'd0);
        check(wr_lanes == '0, "R1 R2 idle wr_lanes", 64'(wr_lanes), 64'd0);
        for (int a = 0; a < DEPTH; a += 2) begin
            do_read(a, a + 1);
            check_port(0, 64'h0, "R1 reset read p0");
            check_port(1, 64'h0, "R1 reset read p1");
        end

        // R2/R3/R4/R8: full-width sweep over every zero-byte mask
        for (int m = 0; m < 256; m++) begin
            int a = m % DEPTH;
            int o = (m + 3) % DEPTH;
            do_write(a, mk(m, m), 1'b0, $countones(8'(m)), "R2 wr_lanes full");
            do_read(a, o);
            check_port(0, model[a], "R3 full readback p0");
            check_port(1, model[o], "R8 other address p1");
        end

        // R5: narrow sweep with garbage upper half
        for (int m = 0; m < 256; m++) begin
            int a = (m * 3) % DEPTH;
            do_write(a, mk(m, m + 5), 1'b1, $countones(4'(m)), "R5 wr_lanes narrow");
            do_read(a, a);
            check_port(0, model[a], "R5 narrow readback p0");
            check_port(1, model[a], "R8 same address p1");
        end

        // R9: disabled write has no effect
        do_write(1, 64'h1122_0000_3344_0055, 1'b0, 5, "R2 setup for R9");
        wr_en = 1'b0; wr_addr = 3'd1; wr_data = '1; wr_narrow = 1'b1;
        #1;
        check(wr_lanes == '0, "R2 wr_lanes while idle", 64'(wr_lanes), 64'd0);
        @(negedge clk);
        do_read(1, 1);
        check_port(0, 64'h1122_0000_3344_0055, "R9 idle write p0");

        // R6: read-before-write on the same address
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 64'h00AB_0000_0000_CD00; wr_narrow = 1'b0;
        rd_en = 2'b11; rd_addr = {3'd1, 3'd1};
        @(negedge clk);
        wr_en = 1'b0; rd_en = 2'b00;
        check_port(0, 64'h1122_0000_3344_0055, "R6 old word p0");
        check_port(1, 64'h1122_0000_3344_0055, "R6 old word p1");
        model[1] = 64'h00AB_0000_0000_CD00;
        // R7: idle ports go quiet
        @(negedge clk);
        check(rd_valid == '0, "R7 idle valid", 64'(rd_valid), 64'd0);
        check(rd_data == '0, "R7 idle data", rd_data[63:0], 64'd0);
        check(rd_lanes == '0, "R7 idle lanes", 64'(rd_lanes), 64'd0);
        do_read(1, 1);
        check_port(0, 64'h00AB_0000_0000_CD00, "R6 new word p0");

        // R3: all-ones and all-zero words
        do_write(6, '1, 1'b0, 8, "R2 all ones");
        do_write(7, '0, 1'b0, 0, "R2 all zero");
        do_read(6, 7);
        check_port(0, 64'hFFFF_FFFF_FFFF_FFFF, "R3 all ones");
        check_port(1, 64'h0, "R3 all zero overwrite");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule